// File: doc/BRIEF.md
# Serial port control and status registers

This block is the register front end of a serial port. A host reaches it through a simple synchronous bus with a 6-bit byte offset. Two mode registers sit behind a pointer that advances after a write. A status view and an interrupt status view are assembled from the live transmit and receive state. An interrupt mask gates one level interrupt line. A single command byte packs three independent fields. One field carries miscellaneous resets, one controls the transmitter and one controls the receiver.

Outbound bytes wait in a one-byte holding register and leave on a valid/ready port whenever the transmitter is enabled. Inbound bytes are accepted from a valid/ready port into a small queue that the host drains by reading the data offset. A line-break event pushes a zero byte into that queue and raises a sticky flag. The receive interrupt can follow either "queue non-empty" or "queue full", as chosen by a mode bit. Bit-level serialization, baud arithmetic, the input-port change view and auxiliary control are outside the block. Their offsets read as zero.

Top module: `sio_csr`

## Requirements
- R1: Only `addr_i` (6 bits) selects a register. Writes to offsets 0x04, 0x10, 0x18 and 0x1C have no effect. Offsets 0x18 and 0x1C read the parameters `DIV_HI` and `DIV_LO`. Offset 0x10 and every unmapped offset read 0x00. `rdata_o` is 0 when no read is requested.
- R2: Offset 0x00 reads and writes the mode register chosen by a pointer (0 = first, 1 = second). Every write stores into the chosen register and then sets the pointer to 1. Reads leave the pointer unchanged.
- R3: A read of offset 0x04 returns the status byte. Bit0 is set when the receive queue is non-empty. Bit1 is set when the queue holds `RX_DEPTH` bytes. Bit2 equals the transmitter enable. Bit3 is transmit-empty. Bits 7:4 read 0.
- R4: A write to offset 0x08 is a command, and its bits 6:4 select a miscellaneous action. A value of 1 sets the mode pointer to 0. A value of 2 disables the receiver and empties the queue. A value of 3 disables the transmitter and sets transmit-empty. A value of 5 clears the break flag. Values 0, 4, 6 and 7 do nothing.
- R5: In the same command, bits 3:2 control the transmitter and bits 1:0 control the receiver. In both fields 1 enables, 2 disables, and 0 and 3 have no effect. The fields apply in the order miscellaneous, transmitter, receiver, so a later field overrides an earlier one.
- R6: A write to offset 0x0C latches the byte and clears transmit-empty. `tx_valid_o` is high exactly when the transmitter is enabled and transmit-empty is clear. While `tx_ready_i` is low, `tx_data_o` holds. The cycle after `tx_valid_o` and `tx_ready_i` are both high, transmit-empty is set again. A new write before acceptance replaces the held byte.
- R7: `rx_ready_o` is high when the receiver is enabled, the queue is not full and `rx_break_i` is low. Accepted bytes are returned in arrival order by reads of offset 0x0C, one per read. A read of an empty queue returns 0x00 and changes nothing. A read and an accepted byte may share a cycle.
- R8: A cycle with `rx_break_i` high sets the break flag and pushes 0x00 into the queue, whatever the receiver enable. If the queue is full, the zero byte overwrites the newest entry. A break sets the flag even when a same-cycle command clears it.
- R9: A read of offset 0x14 returns the interrupt status. Bit0 equals transmit-ready. Bit1 equals queue-full when bit6 of the first mode register is set, and queue-non-empty otherwise. Bit2 is the break flag. Bits 7:3 read 0.
- R10: A write to offset 0x14 sets the interrupt mask. `irq_o` is high whenever the interrupt status ANDed with the mask is non-zero.
- R11: After reset both mode registers, the mask and the break flag are zero. The pointer selects the first register, both directions are disabled, the queue is empty, and the status reads 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access in this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, same cycle as the request |
| tx_valid_o | output | 1 | Held transmit byte is offered |
| tx_ready_i | input | 1 | Downstream takes the offered byte |
| tx_data_o | output | 8 | Held transmit byte |
| rx_valid_i | input | 1 | Inbound byte present |
| rx_ready_o | output | 1 | Inbound byte is accepted |
| rx_data_i | input | 8 | Inbound byte |
| rx_break_i | input | 1 | Line-break event, one per cycle high |
| irq_o | output | 1 | Level interrupt |

## Verification
Read data is combinational and is due in the request cycle. The side effects of any write, pop, accepted byte or break appear in the status and interrupt views, in `tx_valid_o`/`rx_ready_o` and in `irq_o` one clock later. The bench drives every input just after a falling edge. One nanosecond later it compares every output against a behavioural model, and it advances the model at the rising edge, so each result is compared in the cycle it is due. Directed reads with hand-computed values cover the ordering inside one command byte, overwrite on a full queue, same-cycle pop and push, and break with the receiver disabled.

// File: rtl/sio_csr_pkg.sv
package sio_csr_pkg;

  localparam int unsigned DW    = 8;
  localparam int unsigned OFS_W = 6;

  localparam logic [OFS_W-1:0] OFS_MODE = 6'h00;
  localparam logic [OFS_W-1:0] OFS_STAT = 6'h04;
  localparam logic [OFS_W-1:0] OFS_CMD  = 6'h08;
  localparam logic [OFS_W-1:0] OFS_DATA = 6'h0C;
  localparam logic [OFS_W-1:0] OFS_INT  = 6'h14;
  localparam logic [OFS_W-1:0] OFS_DIVH = 6'h18;
  localparam logic [OFS_W-1:0] OFS_DIVL = 6'h1C;

  // first mode register bit selecting queue-full receive interrupt
  localparam int unsigned MODE_RXFULL_BIT = 6;
  localparam int unsigned N_MODE          = 2;

  typedef struct packed {
    logic ptr_rst;
    logic rx_rst;
    logic tx_rst;
    logic brk_clr;
    logic tx_on;
    logic tx_off;
    logic rx_on;
    logic rx_off;
  } cmd_act_t;

endpackage

// File: rtl/sio_cmd_dec.sv
module sio_cmd_dec
  import sio_csr_pkg::*;
(
  input  logic       valid_i,
  input  logic [6:0] cmd_i,
  output cmd_act_t   act_o
);

  always_comb begin
    act_o = '0;
    if (valid_i) begin
      unique case (cmd_i[6:4])
        3'd1:    act_o.ptr_rst = 1'b1;
        3'd2:    act_o.rx_rst  = 1'b1;
        3'd3:    act_o.tx_rst  = 1'b1;
        3'd5:    act_o.brk_clr = 1'b1;
        default: ;
      endcase
      unique case (cmd_i[3:2])
        2'd1:    act_o.tx_on  = 1'b1;
        2'd2:    act_o.tx_off = 1'b1;
        default: ;
      endcase
      unique case (cmd_i[1:0])
        2'd1:    act_o.rx_on  = 1'b1;
        2'd2:    act_o.rx_off = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sio_tx_hold.sv
module sio_tx_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         rst_cmd_i,
  input  logic         on_i,
  input  logic         off_i,
  input  logic         ready_i,
  output logic         en_o,
  output logic         empty_o,
  output logic         valid_o,
  output logic [W-1:0] data_o
);

  logic         en_q, empty_q;
  logic [W-1:0] buf_q;

  assign valid_o = en_q & ~empty_q;
  assign en_o    = en_q;
  assign empty_o = empty_q;
  assign data_o  = buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      empty_q <= 1'b1;
      buf_q   <= '0;
    end else begin
      // later command field wins over the miscellaneous reset
      if (on_i)                        en_q <= 1'b1;
      else if (off_i || rst_cmd_i)     en_q <= 1'b0;

      if (load_i) begin
        empty_q <= 1'b0;
        buf_q   <= data_i;
      end else if (rst_cmd_i || (valid_o && ready_i)) begin
        empty_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sio_rx_fifo.sv
module sio_rx_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          pop_i,
  input  logic          wr_i,
  input  logic [W-1:0]  wr_data_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o
);

  logic [W-1:0]  mem_q [DEPTH];
  logic [W-1:0]  mem_n [DEPTH];
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    mem_n = mem_q;
    cnt_n = cnt_q;
    if (pop_i && cnt_q != '0) begin
      for (int i = 0; i < int'(DEPTH) - 1; i++) mem_n[i] = mem_q[i+1];
      cnt_n = cnt_q - 1'b1;
    end
    if (clr_i) begin
      cnt_n = '0;
    end else if (wr_i) begin
      if (cnt_n == CW'(DEPTH)) begin
        mem_n[DEPTH-1] = wr_data_i;  // overwrite newest entry
      end else begin
        for (int i = 0; i < int'(DEPTH); i++)
          if (CW'(i) == cnt_n) mem_n[i] = wr_data_i;
        cnt_n = cnt_n + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else begin
      cnt_q <= cnt_n;
      mem_q <= mem_n;
    end
  end

  assign head_o = mem_q[0];
  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == CW'(DEPTH));

endmodule

// File: rtl/sio_csr.sv
module sio_csr
  import sio_csr_pkg::*;
#(
  parameter int unsigned RX_DEPTH = 4,
  parameter logic [7:0]  DIV_HI   = 8'h01,
  parameter logic [7:0]  DIV_LO   = 8'h2C,
  localparam int unsigned CW      = $clog2(RX_DEPTH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       we_i,
  input  logic [5:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       tx_valid_o,
  input  logic       tx_ready_i,
  output logic [7:0] tx_data_o,
  input  logic       rx_valid_i,
  output logic       rx_ready_o,
  input  logic [7:0] rx_data_i,
  input  logic       rx_break_i,
  output logic       irq_o
);

  logic          wr_en, rd_en;
  logic [DW-1:0] mode_q [N_MODE];
  logic          mode_ptr;
  logic [DW-1:0] imr;
  logic          brk_q, rx_en_q;
  cmd_act_t      act;
  logic          tx_en, tx_empty;
  logic [DW-1:0] rx_head;
  logic [CW-1:0] rx_cnt;
  logic          rx_full, rx_push, rx_nempty;
  logic [DW-1:0] status, isr;

  assign wr_en = req_i & we_i;
  assign rd_en = req_i & ~we_i;

  sio_cmd_dec i_cmd_dec (
    .valid_i (wr_en && addr_i == OFS_CMD),
    .cmd_i   (wdata_i[6:0]),
    .act_o   (act)
  );

  sio_tx_hold #(.W(DW)) i_tx_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (wr_en && addr_i == OFS_DATA),
    .data_i    (wdata_i),
    .rst_cmd_i (act.tx_rst),
    .on_i      (act.tx_on),
    .off_i     (act.tx_off),
    .ready_i   (tx_ready_i),
    .en_o      (tx_en),
    .empty_o   (tx_empty),
    .valid_o   (tx_valid_o),
    .data_o    (tx_data_o)
  );

  assign rx_ready_o = rx_en_q & ~rx_full & ~rx_break_i;
  assign rx_push    = rx_valid_i & rx_ready_o;
  assign rx_nempty  = (rx_cnt != '0);

  sio_rx_fifo #(.DEPTH(RX_DEPTH), .W(DW)) i_rx_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (act.rx_rst),
    .pop_i     (rd_en && addr_i == OFS_DATA),
    .wr_i      (rx_push | rx_break_i),
    .wr_data_i (rx_break_i ? '0 : rx_data_i),
    .head_o    (rx_head),
    .cnt_o     (rx_cnt),
    .full_o    (rx_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(N_MODE); i++) mode_q[i] <= '0;
      mode_ptr <= 1'b0;
      imr      <= '0;
      brk_q    <= 1'b0;
      rx_en_q  <= 1'b0;
    end else begin
      if (wr_en && addr_i == OFS_MODE) begin
        mode_q[mode_ptr] <= wdata_i;
        mode_ptr         <= 1'b1;
      end else if (act.ptr_rst) begin
        mode_ptr <= 1'b0;
      end
      if (wr_en && addr_i == OFS_INT) imr <= wdata_i;
      if (rx_break_i)        brk_q <= 1'b1;
      else if (act.brk_clr)  brk_q <= 1'b0;
      if (act.rx_on)                      rx_en_q <= 1'b1;
      else if (act.rx_off || act.rx_rst)  rx_en_q <= 1'b0;
    end
  end

  assign status = {4'b0, tx_empty, tx_en, rx_full, rx_nempty};
  assign isr    = {5'b0, brk_q,
                   (mode_q[0][MODE_RXFULL_BIT] ? rx_full : rx_nempty),
                   tx_en};
  assign irq_o  = |(isr & imr);

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      unique case (addr_i)
        OFS_MODE: rdata_o = mode_q[mode_ptr];
        OFS_STAT: rdata_o = status;
        OFS_DATA: rdata_o = rx_nempty ? rx_head : '0;
        OFS_INT:  rdata_o = isr;
        OFS_DIVH: rdata_o = DIV_HI;
        OFS_DIVL: rdata_o = DIV_LO;
        default:  rdata_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/sio_csr_chk.sv
module sio_csr_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic [5:0]    addr_i,
  input logic [7:0]    wdata_i,
  input logic          tx_valid_o,
  input logic          tx_ready_i,
  input logic [7:0]    tx_data_o,
  input logic          rx_ready_o,
  input logic          irq_o,
  input logic [7:0]    imr,
  input logic          mode_ptr,
  input logic [CW-1:0] rx_cnt
);

  logic wr_mode, wr_cmd, wr_data;
  assign wr_mode = req_i && we_i && addr_i == 6'h00;
  assign wr_cmd  = req_i && we_i && addr_i == 6'h08;
  assign wr_data = req_i && we_i && addr_i == 6'h0C;

  // R2
  mode_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mode |=> mode_ptr);

  // R4
  ptr_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && wdata_i[6:4] == 3'd1) |=> !mode_ptr);

  // R4
  rx_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && wdata_i[6:4] == 3'd2) |=> rx_cnt == '0);

  // R6
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !wr_data && !wr_cmd)
      |=> (tx_valid_o && $stable(tx_data_o)));

  // R6
  tx_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_ready_i && !wr_data) |=> !tx_valid_o);

  // R7
  rx_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |-> (rx_cnt < CW'(DEPTH)));

  // R10
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imr == '0) |-> !irq_o);

endmodule

bind sio_csr sio_csr_chk #(.DEPTH(RX_DEPTH), .CW(CW)) i_sio_csr_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .tx_data_o  (tx_data_o),
  .rx_ready_o (rx_ready_o),
  .irq_o      (irq_o),
  .imr        (imr),
  .mode_ptr   (mode_ptr),
  .rx_cnt     (rx_cnt)
);

// File: tb/test_sio_csr.sv
module test_sio_csr;

  localparam int         DEPTH = 4;
  localparam logic [7:0] DH    = 8'h01;
  localparam logic [7:0] DL    = 8'h2C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       req = 0, we = 0, tx_ready = 0, rx_valid = 0, rx_break = 0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0, rx_data = '0;
  logic [7:0] rdata, tx_data;
  logic       tx_valid, rx_ready, irq;

  sio_csr #(.RX_DEPTH(DEPTH), .DIV_HI(DH), .DIV_LO(DL)) i_sio_csr (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_valid_o(tx_valid),
    .tx_ready_i(tx_ready), .tx_data_o(tx_data), .rx_valid_i(rx_valid),
    .rx_ready_o(rx_ready), .rx_data_i(rx_data), .rx_break_i(rx_break),
    .irq_o(irq)
  );

  // behavioural reference
  logic [7:0] m_mr [2];
  int         m_ptr;
  logic [7:0] m_imr, m_tb;
  bit         m_brk, m_txen, m_rxen, m_txemp;
  logic [7:0] m_q [$];

  int n_tests = 0, n_fail = 0;

  task automatic m_reset();
    m_mr[0] = 0; m_mr[1] = 0; m_ptr = 0; m_imr = 0; m_tb = 0;
    m_brk = 0; m_txen = 0; m_rxen = 0; m_txemp = 1; m_q.delete();
  endtask

  function automatic logic [7:0] m_status();
    bit full = (m_q.size() == DEPTH);
    bit rdy  = (m_q.size() != 0);
    return {4'b0, m_txemp, m_txen, full, rdy};
  endfunction

  function automatic logic [7:0] m_isr();
    bit full = (m_q.size() == DEPTH);
    bit rdy  = (m_q.size() != 0);
    return {5'b0, m_brk, (m_mr[0][6] ? full : rdy), m_txen};
  endfunction

  function automatic logic [7:0] m_rdata();
    if (!(req && !we)) return 8'h00;
    case (addr)
      6'h00: return m_mr[m_ptr];
      6'h04: return m_status();
      6'h0C: return (m_q.size() != 0) ? m_q[0] : 8'h00;
      6'h14: return m_isr();
      6'h18: return DH;
      6'h1C: return DL;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit m_rx_ready();
    return m_rxen && (m_q.size() < DEPTH) && !rx_break;
  endfunction

  function automatic string tag_of(logic [5:0] a);
    case (a)
      6'h00: return "R2";
      6'h04: return "R3";
      6'h0C: return "R7";
      6'h14: return "R9";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(logic [7:0] act, logic [7:0] exp, string tag, string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    bit tv = m_txen && !m_txemp;
    chk(rdata, m_rdata(), tag_of(addr), "model rdata");
    chk({7'b0, tx_valid}, {7'b0, tv}, "R6", "model tx_valid");
    if (tv) chk(tx_data, m_tb, "R6", "model tx_data");
    chk({7'b0, rx_ready}, {7'b0, m_rx_ready()}, "R7", "model rx_ready");
    chk({7'b0, irq}, {7'b0, |(m_isr() & m_imr)}, "R10", "model irq");
  endtask

  task automatic m_step();
    bit acc_tx = m_txen && !m_txemp && tx_ready;
    bit push   = rx_valid && m_rx_ready();
    bit wr     = req && we;
    if (acc_tx) m_txemp = 1;
    if (req && !we && addr == 6'h0C && m_q.size() != 0) void'(m_q.pop_front());
    if (wr && addr == 6'h08) begin
      case (wdata[6:4])
        3'd1: m_ptr = 0;
        3'd2: begin m_rxen = 0; m_q.delete(); end
        3'd3: begin m_txen = 0; m_txemp = 1; end
        3'd5: m_brk = 0;
        default: ;
      endcase
      if (wdata[3:2] == 2'd1) m_txen = 1;
      if (wdata[3:2] == 2'd2) m_txen = 0;
      if (wdata[1:0] == 2'd1) m_rxen = 1;
      if (wdata[1:0] == 2'd2) m_rxen = 0;
    end
    if (!(wr && addr == 6'h08 && wdata[6:4] == 3'd2)) begin
      if (rx_break) begin
        if (m_q.size() == DEPTH) void'(m_q.pop_back());
        m_q.push_back(8'h00);
      end else if (push) begin
        m_q.push_back(rx_data);
      end
    end
    if (rx_break) m_brk = 1;
    if (wr && addr == 6'h00) begin m_mr[m_ptr] = wdata; m_ptr = 1; end
    if (wr && addr == 6'h0C) begin m_tb = wdata; m_txemp = 0; end
    if (wr && addr == 6'h14) m_imr = wdata;
  endtask

  task automatic tick();
    #1 compare();
    @(posedge clk);
    m_step();
    @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    tick();
    req = 0; we = 0;
  endtask

  task automatic rd(logic [5:0] a, logic [7:0] exp, string tag);
    req = 1; we = 0; addr = a;
    #1 chk(rdata, exp, tag, "read");
    tick();
    req = 0;
  endtask

  task automatic push(logic [7:0] d);
    rx_valid = 1; rx_data = d;
    tick();
    rx_valid = 0;
  endtask

  task automatic brk();
    rx_break = 1;
    tick();
    rx_break = 0;
  endtask

  task automatic out(logic v, logic exp, string tag, string what);
    #1 chk({7'b0, v}, {7'b0, exp}, tag, what);
  endtask

  task automatic do_reset();
    rst_n = 0; m_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11 reset state
    rd(6'h04, 8'h08, "R11");
    rd(6'h14, 8'h00, "R11");
    rd(6'h00, 8'h00, "R11");
    out(irq, 0, "R11", "irq");
    out(tx_valid, 0, "R11", "tx_valid");
    out(rx_ready, 0, "R11", "rx_ready");

    // R1 decode
    wr(6'h04, 8'hFF);
    rd(6'h04, 8'h08, "R1");
    wr(6'h10, 8'hFF);
    rd(6'h10, 8'h00, "R1");
    rd(6'h18, DH, "R1");
    wr(6'h18, 8'h55);
    rd(6'h18, DH, "R1");
    rd(6'h1C, DL, "R1");
    rd(6'h3C, 8'h00, "R1");
    rd(6'h0C, 8'h00, "R7");

    // R2 mode pointer
    wr(6'h00, 8'hA5);
    wr(6'h00, 8'h3C);
    wr(6'h00, 8'h77);
    rd(6'h00, 8'h77, "R2");
    rd(6'h00, 8'h77, "R2");
    wr(6'h08, 8'h10);
    rd(6'h00, 8'hA5, "R4");
    wr(6'h00, 8'h00);

    // R6 transmit path
    wr(6'h14, 8'h01);
    wr(6'h08, 8'h04);
    out(irq, 1, "R10", "irq tx");
    rd(6'h04, 8'h0C, "R3");
    rd(6'h14, 8'h01, "R9");
    wr(6'h0C, 8'h5A);
    out(tx_valid, 1, "R6", "tx_valid");
    #1 chk(tx_data, 8'h5A, "R6", "tx_data");
    rd(6'h04, 8'h04, "R3");
    repeat (3) tick();
    wr(6'h0C, 8'h66);
    #1 chk(tx_data, 8'h66, "R6", "tx_data replaced");
    tx_ready = 1; tick(); tx_ready = 0;
    out(tx_valid, 0, "R6", "tx_valid after accept");
    rd(6'h04, 8'h0C, "R3");
    wr(6'h08, 8'h08);
    out(irq, 0, "R10", "irq tx off");
    rd(6'h04, 8'h08, "R5");
    wr(6'h0C, 8'h11);
    rd(6'h04, 8'h00, "R3");
    out(tx_valid, 0, "R6", "tx_valid disabled");
    wr(6'h08, 8'h30);
    rd(6'h04, 8'h08, "R4");
    wr(6'h0C, 8'h22);
    wr(6'h08, 8'h34);
    rd(6'h04, 8'h0C, "R5");
    out(tx_valid, 0, "R5", "tx_valid after reset+enable");
    wr(6'h08, 8'h0C);
    rd(6'h04, 8'h0C, "R5");

    // R7 receive path
    wr(6'h14, 8'h02);
    wr(6'h08, 8'h01);
    out(rx_ready, 1, "R5", "rx_ready");
    out(irq, 0, "R10", "irq empty");
    push(8'h31);
    out(irq, 1, "R9", "irq rx ready");
    rd(6'h04, 8'h0D, "R3");
    push(8'h32); push(8'h33); push(8'h34);
    out(rx_ready, 0, "R7", "rx_ready full");
    rd(6'h04, 8'h0F, "R3");
    push(8'h99);
    rd(6'h0C, 8'h31, "R7");
    rd(6'h0C, 8'h32, "R7");

    // R9 full mode
    wr(6'h08, 8'h10);
    wr(6'h00, 8'h40);
    out(irq, 0, "R9", "irq not full");
    rd(6'h14, 8'h01, "R9");
    push(8'h41); push(8'h42);
    out(irq, 1, "R9", "irq full");
    rd(6'h14, 8'h03, "R9");

    // R8 break on full queue
    brk();
    rd(6'h14, 8'h07, "R8");
    rd(6'h0C, 8'h33, "R8");
    rd(6'h0C, 8'h34, "R8");
    rd(6'h0C, 8'h41, "R8");
    rd(6'h0C, 8'h00, "R8");
    rd(6'h04, 8'h0C, "R8");

    // R7 pop and push together
    push(8'h51); push(8'h52);
    req = 1; we = 0; addr = 6'h0C; rx_valid = 1; rx_data = 8'h53;
    #1 chk(rdata, 8'h51, "R7", "pop with push");
    tick();
    req = 0; rx_valid = 0;
    rd(6'h0C, 8'h52, "R7");
    rd(6'h0C, 8'h53, "R7");

    // R8 break with receiver off
    wr(6'h08, 8'h02);
    out(rx_ready, 0, "R5", "rx_ready off");
    brk();
    rd(6'h04, 8'h0D, "R8");
    rd(6'h0C, 8'h00, "R8");
    wr(6'h08, 8'h50);
    rd(6'h14, 8'h01, "R4");

    // R4/R5 receiver reset then enable
    wr(6'h08, 8'h01);
    push(8'h61); push(8'h62);
    wr(6'h08, 8'h21);
    rd(6'h04, 8'h0C, "R4");
    out(rx_ready, 1, "R5", "rx_ready re-enabled");
    wr(6'h08, 8'h03);
    out(rx_ready, 1, "R5", "reserved rx field");

    // R10 mask
    wr(6'h14, 8'h04);
    out(irq, 0, "R10", "irq masked");
    brk();
    out(irq, 1, "R10", "irq break");
    wr(6'h14, 8'h00);
    out(irq, 0, "R10", "irq mask clear");

    // R11 reset mid-run
    do_reset();
    rd(6'h04, 8'h08, "R11");
    rd(6'h00, 8'h00, "R11");
    wr(6'h00, 8'h5C);
    rd(6'h00, 8'h00, "R11");

    summary();
    $finish;
  end

endmodule